// File: doc/BRIEF.md
# Asynchronous Serial Line Controller

This block gives a processor one asynchronous serial line. It has four 16-bit registers on a simple strobe bus: a status register and a data register for each direction. Each direction also has its own interrupt request and acknowledge pair. Frames are 8N1: one start bit, eight data bits with the LSB first, and one stop bit.

The bit rate comes from two parameters, the fixed clock frequency and a baud rate. The baud rate is legal from 1200 to 230400 and defaults to 9600. An internal tick runs at sixteen times the bit rate. The receiver uses this tick to sample each bit near its middle.

Two per-instance options change the behaviour:
- A strict 7-bit option clears bit 7 of every byte, both on the way in and on the way out.
- A hardware flow-control option turns on the rts output and the cts input, and puts a small receive FIFO in front of the processor.

Without flow control the controller keeps exactly one received byte.

Top module: `slc_top`

## Requirements
- R1: After reset, the receive status register reads 0x0000 and the transmit status register reads 0x0080 (ready). txd is 1, both interrupt requests are 0, and rts is 1.
- R2: Register addresses are fixed:
  - address 0: receive status, with bit 7 = done and bit 6 = interrupt enable.
  - address 1: receive data, with the byte in bits 7:0.
  - address 2: transmit status, with bit 7 = ready and bit 6 = interrupt enable.
  - address 3: transmit data.
  Only the enable bits are writable, and all other bits read 0. Read data appears on bus_rdata one clock after the cycle in which bus_rd is high.
- R3: An 8N1 frame on rxd, sampled near mid-bit, puts its byte into the receive data register and sets done. Reading the receive data register consumes that byte.
- R4: A write to the transmit data register while ready is 1 clears ready. The byte then goes out on txd as 8N1, LSB first, each bit lasting 16 ticks. Ready returns to 1 after the stop bit. txd is 1 whenever ready is 1.
- R5: An interrupt request rises after a byte event only while done/ready and the enable bit are both 1. A byte event is a byte stored by the receiver, or a stop bit finished by the transmitter. The request drops the clock after its acknowledge and stays low until the next byte event. With the enable bit at 0 there is no request.
- R6: With the 7-bit option on, bit 7 reads back as 0 for every received byte and is sent as 0 for every transmitted byte.
- R7: Without flow control, a single holding register keeps the received byte. A newer byte overwrites an unread one.
- R8: With flow control on, received bytes queue in a FIFO of FIFO_DEPTH entries and are read in arrival order. Bytes that arrive while the FIFO is full are dropped.
- R9: With flow control on, rts is 0 while the FIFO has two or fewer free entries, and 1 otherwise.
- R10: With flow control on, no frame starts while cts is 0. A pending byte starts once cts is 1.
- R11: A frame whose stop bit is sampled as 0 is discarded. The receiver then waits for the line to return to 1 before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| rx_irq | output | 1 | Receive interrupt request |
| rx_irq_ack | input | 1 | Receive interrupt acknowledge |
| tx_irq | output | 1 | Transmit interrupt request |
| tx_irq_ack | input | 1 | Transmit interrupt acknowledge |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |
| rts | output | 1 | Ready to receive, active high |
| cts | input | 1 | Peer ready, active high |

## Verification
Register reads are due one clock after the strobe, so the bench samples bus_rdata at the falling edge that follows the strobe cycle.

A received byte becomes visible about half a bit into the stop bit. That is two synchronizer stages plus up to one tick after the sample point. The bench therefore checks status only once the whole frame has been driven plus a margin.

Transmit frames start within a tick of the write, or of cts rising plus two synchronizer clocks. The bench finds the falling start edge and samples each following bit at its middle.

An interrupt acknowledge takes effect on the next edge, so the bench checks the request one falling edge after releasing the acknowledge.

// File: rtl/slc_pkg.sv
package slc_pkg;
  localparam logic [1:0] ADDR_RSTAT = 2'd0;
  localparam logic [1:0] ADDR_RDATA = 2'd1;
  localparam logic [1:0] ADDR_TSTAT = 2'd2;
  localparam logic [1:0] ADDR_TDATA = 2'd3;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int OVS      = 16;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT} rx_state_t;
  typedef enum logic {TX_IDLE, TX_SEND} tx_state_t;
endpackage

// File: rtl/slc_tick_gen.sv
module slc_tick_gen #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      tick  <= 1'b0;
    end
  end
endmodule

// File: rtl/slc_rx.sv
module slc_rx
  import slc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       rxd,
  output logic [7:0] byte_o,
  output logic       valid_o
);
  logic       s1_q, s2_q;
  rx_state_t  st_q;
  logic [3:0] cnt_q;
  logic [2:0] idx_q;
  logic [7:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
    end else begin
      s1_q <= rxd;
      s2_q <= s1_q;
    end
  end

  // R3 mid-bit sampling, R11 stop-bit validation
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RX_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      byte_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (tick) begin
        case (st_q)
          RX_IDLE: if (!s2_q) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == 4'(OVS/2 - 1)) begin
              cnt_q <= '0;
              idx_q <= '0;
              st_q  <= s2_q ? RX_IDLE : RX_DATA;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_DATA: begin
            if (cnt_q == 4'(OVS - 1)) begin
              cnt_q <= '0;
              sh_q  <= {s2_q, sh_q[7:1]};
              if (idx_q == 3'd7) st_q <= RX_STOP;
              else idx_q <= idx_q + 1'b1;
            end else cnt_q <= cnt_q + 1'b1;
          end
          RX_STOP: begin
            if (cnt_q == 4'(OVS - 1)) begin
              cnt_q <= '0;
              if (s2_q) begin
                byte_o  <= sh_q;
                valid_o <= 1'b1;
                st_q    <= RX_IDLE;
              end else st_q <= RX_WAIT;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: if (s2_q) st_q <= RX_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/slc_tx.sv
module slc_tx
  import slc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] din,
  input  logic       cts_ok,
  output logic       txd,
  output logic       ready,
  output logic       done_pulse
);
  tx_state_t  st_q;
  logic       pend_q;
  logic [7:0] hold_q;
  logic [8:0] sh_q;
  logic [3:0] cnt_q;
  logic [3:0] bitn_q;

  // R4 frame generation, R10 start gated by cts_ok
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= TX_IDLE;
      pend_q     <= 1'b0;
      hold_q     <= '0;
      sh_q       <= '1;
      cnt_q      <= '0;
      bitn_q     <= '0;
      txd        <= 1'b1;
      ready      <= 1'b1;
      done_pulse <= 1'b0;
    end else begin
      done_pulse <= 1'b0;
      if (load && ready) begin
        hold_q <= din;
        pend_q <= 1'b1;
        ready  <= 1'b0;
      end
      if (tick) begin
        case (st_q)
          TX_IDLE: if (pend_q && cts_ok) begin
            sh_q   <= {1'b1, hold_q};
            txd    <= 1'b0;
            cnt_q  <= '0;
            bitn_q <= '0;
            pend_q <= 1'b0;
            st_q   <= TX_SEND;
          end
          default: begin
            if (cnt_q == 4'(OVS - 1)) begin
              cnt_q <= '0;
              if (bitn_q == 4'd9) begin
                st_q       <= TX_IDLE;
                ready      <= 1'b1;
                done_pulse <= 1'b1;
              end else begin
                txd    <= sh_q[0];
                sh_q   <= {1'b1, sh_q[8:1]};
                bitn_q <= bitn_q + 1'b1;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end
endmodule

// File: rtl/slc_rx_fifo.sv
module slc_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 head,
  output logic [$clog2(DEPTH+1)-1:0]   fill,
  output logic                         pushed
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic          do_pop;

  assign pushed = push && (fill != FW'(DEPTH));   // R8 drop when full
  assign do_pop = pop && (fill != '0);
  assign head   = mem[rptr_q];

  always_ff @(posedge clk) begin
    if (pushed) mem[wptr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      fill   <= '0;
    end else begin
      if (pushed) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop) rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      if (pushed && !do_pop)      fill <= fill + 1'b1;
      else if (do_pop && !pushed) fill <= fill - 1'b1;
    end
  end
endmodule

// File: rtl/slc_top.sv
module slc_top
  import slc_pkg::*;
#(
  parameter int CLK_HZ     = 50_000_000,
  parameter int BAUD       = 9600,
  parameter int FLOW_CTRL  = 0,
  parameter int FORCE_7BIT = 0,
  parameter int FIFO_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        rx_irq,
  input  logic        rx_irq_ack,
  output logic        tx_irq,
  input  logic        tx_irq_ack,
  input  logic        rxd,
  output logic        txd,
  output logic        rts,
  input  logic        cts
);
  localparam int DIV_RAW = CLK_HZ / (BAUD * OVS);
  localparam int DIV     = (DIV_RAW < 1) ? 1 : DIV_RAW;
  localparam int FILL_W  = $clog2(FIFO_DEPTH + 1);

  logic              tick;
  logic [7:0]        rx_byte, rx_byte_m, rx_head, tx_byte_m;
  logic              rx_valid, rx_event, rx_done;
  logic [FILL_W-1:0] rx_fill;
  logic              rd_rdata, wr_tdata;
  logic              tx_ready, tx_event;
  logic              cts_s1, cts_s;
  logic              rx_ie_q, tx_ie_q;
  logic              rx_arm_q, tx_arm_q, rx_arm_d, tx_arm_d;
  logic [15:0]       rd_mux;
  logic              unused_hi;

  assign unused_hi = &bus_wdata[15:8];
  assign rd_rdata  = bus_rd && (bus_addr == ADDR_RDATA);
  assign wr_tdata  = bus_wr && (bus_addr == ADDR_TDATA);

  // R6 strict 7-bit in both directions
  assign rx_byte_m = (FORCE_7BIT != 0) ? {1'b0, rx_byte[6:0]} : rx_byte;
  assign tx_byte_m = (FORCE_7BIT != 0) ? {1'b0, bus_wdata[6:0]} : bus_wdata[7:0];

  slc_tick_gen #(.DIV(DIV)) u_tick (.clk(clk), .rst(rst), .tick(tick));

  slc_rx u_rx (.clk(clk), .rst(rst), .tick(tick), .rxd(rxd),
               .byte_o(rx_byte), .valid_o(rx_valid));

  always_ff @(posedge clk) begin
    if (rst) begin
      cts_s1 <= 1'b0;
      cts_s  <= 1'b0;
    end else begin
      cts_s1 <= cts;
      cts_s  <= cts_s1;
    end
  end

  slc_tx u_tx (.clk(clk), .rst(rst), .tick(tick), .load(wr_tdata), .din(tx_byte_m),
               .cts_ok((FLOW_CTRL != 0) ? cts_s : 1'b1), .txd(txd),
               .ready(tx_ready), .done_pulse(tx_event));

  generate
    if (FLOW_CTRL != 0) begin : g_flow
      logic rts_q;
      slc_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
        .clk(clk), .rst(rst), .push(rx_valid), .din(rx_byte_m), .pop(rd_rdata),
        .head(rx_head), .fill(rx_fill), .pushed(rx_event));
      // R9 rts low once two or fewer entries are free
      always_ff @(posedge clk) begin
        if (rst) rts_q <= 1'b1;
        else     rts_q <= (rx_fill < FILL_W'(FIFO_DEPTH - 2));
      end
      assign rts = rts_q;
    end else begin : g_single
      logic [7:0] hold_q;
      logic       full_q;
      // R7 single holding register, newest byte wins
      always_ff @(posedge clk) begin
        if (rst) begin
          hold_q <= '0;
          full_q <= 1'b0;
        end else if (rx_valid) begin
          hold_q <= rx_byte_m;
          full_q <= 1'b1;
        end else if (rd_rdata) begin
          full_q <= 1'b0;
        end
      end
      assign rx_head  = hold_q;
      assign rx_fill  = FILL_W'(full_q);
      assign rx_event = rx_valid;
      assign rts      = 1'b1;
    end
  endgenerate

  assign rx_done = (rx_fill != '0);

  // R2 register read mux
  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      ADDR_RSTAT: begin
        rd_mux[FLAG_BIT] = rx_done;
        rd_mux[IE_BIT]   = rx_ie_q;
      end
      ADDR_RDATA: rd_mux[7:0] = rx_done ? rx_head : 8'h00;
      ADDR_TSTAT: begin
        rd_mux[FLAG_BIT] = tx_ready;
        rd_mux[IE_BIT]   = tx_ie_q;
      end
      default: rd_mux = '0;
    endcase
  end

  // R5 per-event arm, cleared by acknowledge
  assign rx_arm_d = rx_event ? 1'b1 : (rx_irq_ack ? 1'b0 : rx_arm_q);
  assign tx_arm_d = tx_event ? 1'b1 : (tx_irq_ack ? 1'b0 : tx_arm_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rx_ie_q   <= 1'b0;
      tx_ie_q   <= 1'b0;
      rx_arm_q  <= 1'b0;
      tx_arm_q  <= 1'b0;
      rx_irq    <= 1'b0;
      tx_irq    <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      if (bus_wr && bus_addr == ADDR_RSTAT) rx_ie_q <= bus_wdata[IE_BIT];
      if (bus_wr && bus_addr == ADDR_TSTAT) tx_ie_q <= bus_wdata[IE_BIT];
      rx_arm_q <= rx_arm_d;
      tx_arm_q <= tx_arm_d;
      rx_irq   <= rx_arm_d && rx_ie_q && rx_done;
      tx_irq   <= tx_arm_d && tx_ie_q && tx_ready;
    end
  end
endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
  parameter int FLOW_CTRL  = 0,
  parameter int FORCE_7BIT = 0,
  parameter int FIFO_DEPTH = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic [1:0]                     bus_addr,
  input logic                           bus_rd,
  input logic [15:0]                    bus_rdata,
  input logic                           rx_irq,
  input logic                           rx_irq_ack,
  input logic                           tx_irq,
  input logic                           tx_irq_ack,
  input logic                           txd,
  input logic                           rts,
  input logic                           cts_s,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] rx_fill,
  input logic                           rx_event,
  input logic                           tx_event,
  input logic                           tx_ready,
  input logic                           rx_ie_q
);
  localparam int FW = $clog2(FIFO_DEPTH + 1);

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    rx_fill <= FW'(FIFO_DEPTH)); // R8
  AST_RTS_THRESHOLD: assert property (@(posedge clk) disable iff (rst)
    (FLOW_CTRL != 0 && rx_fill >= FW'(FIFO_DEPTH - 2)) |=> !rts); // R9
  AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> txd); // R4
  AST_CTS_GATE: assert property (@(posedge clk) disable iff (rst)
    (FLOW_CTRL != 0 && $fell(txd)) |-> $past(cts_s)); // R10
  AST_RX_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (rx_irq_ack && !rx_event) |=> !rx_irq); // R5
  AST_TX_ACK_DROP: assert property (@(posedge clk) disable iff (rst)
    (tx_irq_ack && !tx_event) |=> !tx_irq); // R5
  AST_RX_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(rx_ie_q)); // R5
  AST_SEVEN_BIT_READ: assert property (@(posedge clk) disable iff (rst)
    (FORCE_7BIT != 0 && $past(bus_rd && bus_addr == 2'd1)) |-> !bus_rdata[7]); // R6
endmodule

bind slc_top slc_checker #(
  .FLOW_CTRL(FLOW_CTRL), .FORCE_7BIT(FORCE_7BIT), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .rx_irq(rx_irq), .rx_irq_ack(rx_irq_ack), .tx_irq(tx_irq), .tx_irq_ack(tx_irq_ack),
  .txd(txd), .rts(rts), .cts_s(cts_s), .rx_fill(rx_fill), .rx_event(rx_event),
  .tx_event(tx_event), .tx_ready(tx_ready), .rx_ie_q(rx_ie_q)
);

// File: tb/slc_top_tb_top.sv
module slc_top_tb_top;
  localparam int BIT = 32;   // 16 ticks x divisor 2

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic rd_a = 0, wr_a = 0, rd_m = 0, wr_m = 0;
  logic [15:0] rdata_a, rdata_m;
  logic irq_rx_a, irq_tx_a, irq_rx_m, irq_tx_m;
  logic ack_rx_a = 0, ack_tx_a = 0;
  logic rx_a = 1, rx_m = 1, cts_a = 1;
  logic tx_a, tx_m, rts_a, rts_m;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  slc_top #(.CLK_HZ(7_372_800), .BAUD(230400), .FLOW_CTRL(1), .FORCE_7BIT(0), .FIFO_DEPTH(8)) dut_i (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_a), .bus_rd(rd_a), .bus_wdata(wdata),
    .bus_rdata(rdata_a), .rx_irq(irq_rx_a), .rx_irq_ack(ack_rx_a), .tx_irq(irq_tx_a),
    .tx_irq_ack(ack_tx_a), .rxd(rx_a), .txd(tx_a), .rts(rts_a), .cts(cts_a));

  slc_top #(.CLK_HZ(7_372_800), .BAUD(230400), .FLOW_CTRL(0), .FORCE_7BIT(1), .FIFO_DEPTH(8)) dut_m (
    .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr_m), .bus_rd(rd_m), .bus_wdata(wdata),
    .bus_rdata(rdata_m), .rx_irq(irq_rx_m), .rx_irq_ack(1'b0), .tx_irq(irq_tx_m),
    .tx_irq_ack(1'b0), .rxd(rx_m), .txd(tx_m), .rts(rts_m), .cts(1'b0));

  function automatic [7:0] exp_byte(input [7:0] b, input bit f7);
    return f7 ? {1'b0, b[6:0]} : b;
  endfunction

  task automatic chk(input string req, input [15:0] act, input [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic reg_rd(input bit m, input [1:0] a, output [15:0] d);
    @(negedge clk); addr = a; if (m) rd_m = 1; else rd_a = 1;
    @(negedge clk); rd_a = 0; rd_m = 0;
    d = m ? rdata_m : rdata_a;
  endtask

  task automatic reg_wr(input bit m, input [1:0] a, input [15:0] d);
    @(negedge clk); addr = a; wdata = d; if (m) wr_m = 1; else wr_a = 1;
    @(negedge clk); wr_a = 0; wr_m = 0;
  endtask

  task automatic send(input bit m, input [7:0] b, input bit stop);
    logic [9:0] fr;
    fr = {stop, b, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); if (m) rx_m = fr[k]; else rx_a = fr[k];
      wait_cyc(BIT - 1);
    end
    @(negedge clk); rx_a = 1; rx_m = 1;
    wait_cyc(40);
  endtask

  task automatic capture(input bit m, output [7:0] b, output bit ok);
    int t;
    t = 0; ok = 0; b = '0;
    while (t < 600 && (m ? tx_m : tx_a) !== 1'b0) begin @(negedge clk); t++; end
    if (t < 600) begin
      wait_cyc(BIT/2);
      ok = ((m ? tx_m : tx_a) === 1'b0);
      for (int k = 0; k < 8; k++) begin wait_cyc(BIT); b[k] = m ? tx_m : tx_a; end
      wait_cyc(BIT);
      ok = ok && ((m ? tx_m : tx_a) === 1'b1);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [7:0]  b, q[9], got;
    bit ok;
    void'($urandom(32'd5150));
    wait_cyc(5); rst = 0; wait_cyc(2);

    // R1 reset state
    reg_rd(0, 2'd0, d); chk("R1 rstat", d, 16'h0000);
    reg_rd(0, 2'd2, d); chk("R1 tstat", d, 16'h0080);
    reg_rd(1, 2'd2, d); chk("R1 tstat min", d, 16'h0080);
    chk("R1 lines", {12'h0, tx_a, irq_rx_a, irq_tx_a, rts_a}, 16'h0009);

    // R2 only enable bit writable
    reg_wr(0, 2'd0, 16'hFFFF); reg_rd(0, 2'd0, d); chk("R2 rstat mask", d, 16'h0040);
    reg_wr(0, 2'd0, 16'h0000);

    // R3 random receive
    for (int i = 0; i < 4; i++) begin
      b = 8'($urandom);
      send(0, b, 1);
      reg_rd(0, 2'd0, d); chk("R3 done", d, 16'h0080);
      reg_rd(0, 2'd1, d); chk("R3 data", d, {8'h0, b});
      reg_rd(0, 2'd0, d); chk("R3 done clear", d, 16'h0000);
    end

    // R6 / R7 minimal instance
    send(1, 8'hA5, 1);
    reg_rd(1, 2'd1, d); chk("R6 rx bit7", d, {8'h0, exp_byte(8'hA5, 1)});
    b = 8'($urandom);
    send(1, 8'h3C, 1); send(1, b, 1);
    reg_rd(1, 2'd1, d); chk("R7 overwrite", d, {8'h0, exp_byte(b, 1)});
    reg_rd(1, 2'd0, d); chk("R7 empty", d, 16'h0000);

    // R4 transmit
    for (int i = 0; i < 3; i++) begin
      b = 8'($urandom);
      reg_wr(0, 2'd3, {8'h0, b});
      reg_rd(0, 2'd2, d); chk("R4 busy", d, 16'h0000);
      capture(0, got, ok);
      chk("R4 frame", {7'h0, ok, got}, {8'h01, b});
      wait_cyc(40);
      reg_rd(0, 2'd2, d); chk("R4 ready", d, 16'h0080);
    end
    reg_wr(1, 2'd3, 16'h00FF);
    capture(1, got, ok);
    chk("R6 tx bit7", {7'h0, ok, got}, {8'h01, exp_byte(8'hFF, 1)});
    wait_cyc(40);

    // R5 receive interrupt
    reg_wr(0, 2'd0, 16'h0040);
    send(0, 8'h5A, 1);
    chk("R5 rx irq", {15'h0, irq_rx_a}, 16'h1);
    reg_rd(0, 2'd0, d); chk("R5 rstat", d, 16'h00C0);
    @(negedge clk); ack_rx_a = 1; @(negedge clk); ack_rx_a = 0; @(negedge clk);
    chk("R5 rx ack drop", {15'h0, irq_rx_a}, 16'h0);
    wait_cyc(50);
    chk("R5 no reassert", {15'h0, irq_rx_a}, 16'h0);
    reg_rd(0, 2'd1, d);
    reg_wr(0, 2'd0, 16'h0000);
    send(0, 8'h11, 1);
    chk("R5 ie off", {15'h0, irq_rx_a}, 16'h0);
    reg_rd(0, 2'd1, d); chk("R5 data", d, 16'h0011);

    // R5 transmit interrupt
    reg_wr(0, 2'd2, 16'h0040);
    reg_wr(0, 2'd3, 16'h0042);
    capture(0, got, ok);
    wait_cyc(40);
    chk("R5 tx irq", {15'h0, irq_tx_a}, 16'h1);
    @(negedge clk); ack_tx_a = 1; @(negedge clk); ack_tx_a = 0; @(negedge clk);
    chk("R5 tx ack drop", {15'h0, irq_tx_a}, 16'h0);
    reg_wr(0, 2'd2, 16'h0000);

    // R10 cts gating
    cts_a = 0;
    b = 8'($urandom);
    reg_wr(0, 2'd3, {8'h0, b});
    wait_cyc(400);
    chk("R10 held line", {15'h0, tx_a}, 16'h1);
    reg_rd(0, 2'd2, d); chk("R10 not ready", d, 16'h0000);
    cts_a = 1;
    capture(0, got, ok);
    chk("R10 released", {7'h0, ok, got}, {8'h01, b});
    wait_cyc(40);

    // R11 framing error
    send(0, 8'h77, 0);
    wait_cyc(30);
    reg_rd(0, 2'd0, d); chk("R11 discard", d, 16'h0000);
    send(0, 8'h96, 1);
    reg_rd(0, 2'd1, d); chk("R11 recover", d, 16'h0096);

    // R8 / R9 fifo order, threshold, overflow
    for (int i = 0; i < 9; i++) begin
      q[i] = 8'($urandom);
      send(0, q[i], 1);
      if (i == 4) chk("R9 rts high at 3 free", {15'h0, rts_a}, 16'h1);
      if (i == 5) chk("R9 rts low at 2 free", {15'h0, rts_a}, 16'h0);
    end
    for (int i = 0; i < 8; i++) begin
      reg_rd(0, 2'd1, d); chk("R8 order", d, {8'h0, q[i]});
    end
    reg_rd(0, 2'd0, d); chk("R8 overflow dropped", d, 16'h0000);
    wait_cyc(2);
    chk("R9 rts restored", {15'h0, rts_a}, 16'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule